// File: doc/BRIEF.md
# Multi-outcome Bloom classification cache

This block remembers, for flows that a full classifier has already resolved, which one of `NUM_OUT` outcomes (for example an egress port) each flow belongs to. Storage is split into `LEVELS` levels of `2**BIN_AW` bins. Every bin is a `NUM_OUT`-bit word in which each bit position stands for one outcome. One access per level therefore serves all outcomes at once. Hash generation, the classifier and aging of the table live outside the block.

An insert carries the flow hash, with one `BIN_AW`-bit bin index per level, a small rotation value and the outcome index. It sets one bit in the addressed bin of every level. The bit is the outcome index plus the rotation, modulo `NUM_OUT`. The rotation spreads heavily skewed outcome populations evenly over the bit positions. A query ANDs the addressed words of all levels. A single surviving bit is converted back to an outcome by subtracting the rotation. Zero surviving bits, or more than one, give a miss, and the caller then sends the flow to full classification.

`NUM_OUT` must be a power of two, so the modulo is a bit mask. With `NUM_OUT = 1` the block reduces to a plain single-predicate membership filter.

Top module: `mp_bloom_cache`

## Requirements
- R1: After a synchronous active-low reset, `rsp_valid` is 0 and every bin is empty, so any query misses. A reset in mid-operation also empties all bins.
- R2: A query presented in cycle t is answered in cycle t+1, with `rsp_valid` high for exactly that cycle. `rsp_valid` is 0 in any cycle that does not follow a query.
- R3: An insert with outcome i and rotation r sets bit (i + r) mod NUM_OUT in the addressed bin of every level. A later query with the same hash and rotation reports a hit with outcome i.
- R4: If the AND of the addressed words is all zero, the response is a miss and `rsp_outcome` is 0.
- R5: If more than one bit survives the AND, the response is a miss.
- R6: The stored bit depends on the rotation. With NUM_OUT = 8, outcome 2 and rotation 3, bit 5 is stored, so a query with the same hash and rotation 0 reports outcome 5.
- R7: The reported outcome is (j − r) mod NUM_OUT for surviving bit j and query rotation r, and it wraps correctly. Outcome 6 inserted with rotation 5 is stored at bit 3 and is reported as 6.
- R8: Inserts only set bits. An earlier entry still hits after inserts to other bins.
- R9: An insert in cycle t is visible to a query in cycle t+1. A query in the same cycle t sees the table as it was before that insert.
- R10: Back-to-back inserts to the same bins keep the bits of both inserts, because the pending write is forwarded.
- R11: A hit needs the outcome bit in every level. A hash whose bins hold the bit in only some levels misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ins_valid | input | 1 | Insert request this cycle |
| ins_hash | input | LEVELS*BIN_AW | Bin index per level; level k uses bits [k*BIN_AW +: BIN_AW] |
| ins_rot | input | OW | Rotation value of the inserted flow |
| ins_outcome | input | OW | Outcome index to record |
| qry_valid | input | 1 | Query request this cycle |
| qry_hash | input | LEVELS*BIN_AW | Bin index per level, same layout as `ins_hash` |
| qry_rot | input | OW | Rotation value of the queried flow |
| rsp_valid | output | 1 | Response to the query of the previous cycle |
| rsp_hit | output | 1 | Exactly one outcome bit survived |
| rsp_outcome | output | OW | Decoded outcome index; 0 on a miss |

OW is clog2(NUM_OUT), or 1 when NUM_OUT is 1.

## Verification
The hardest case to reach is two inserts in consecutive cycles that address the same bins. The second read then overlaps the first write, which is still pending. Only a correct forward keeps both bits. The bench drives two such inserts in consecutive cycles, with different outcomes. It then queries that hash and expects the ambiguous miss that appears only when both bits survived. A companion case puts an insert and a query on the same cycle, and then the same query one cycle later, to pin down exactly when an insert becomes visible.

// File: rtl/mpbc_pkg.sv
// Package: shared helpers for the multi-outcome Bloom cache.
// Assumes every modulus passed in is a power of two.
package mpbc_pkg;

    // Wrap a value into 0..n-1 for a power-of-two n.
    function automatic int unsigned wrap_pow2(input int unsigned v, input int unsigned n);
        return v & (n - 1);
    endfunction

    // Width of an index into n items, at least one bit.
    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/mpbc_level.sv
// One storage level: 2**BIN_AW bins of NUM_OUT bits each.
// An insert is a two-stage read-modify-write. Stage A reads the bin and ORs
// in the mask. Stage B writes the word back. A stage-A read or a query read
// that hits the bin under a pending write takes the pending word.
// Assumes at most one insert per cycle. Reset clears all bins.
module mpbc_level #(
    parameter int unsigned NUM_OUT = 8,
    parameter int unsigned BIN_AW  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ins_en,
    input  logic [BIN_AW-1:0]  ins_bin,
    input  logic [NUM_OUT-1:0] ins_mask,
    input  logic [BIN_AW-1:0]  qry_bin,
    output logic [NUM_OUT-1:0] qry_word
);
    localparam int unsigned NBINS = 1 << BIN_AW;

    logic [NUM_OUT-1:0] bins_q [NBINS];
    logic               pend_v;
    logic [BIN_AW-1:0]  pend_bin;
    logic [NUM_OUT-1:0] pend_word;
    logic [NUM_OUT-1:0] rd_fwd;

    // Stage-A read, taking the pending write when it targets the same bin.
    always_comb begin
        if (pend_v && (pend_bin == ins_bin)) rd_fwd = pend_word;
        else                                 rd_fwd = bins_q[ins_bin];
    end

    // Query read, with the same forwarding from the pending write.
    always_comb begin
        if (pend_v && (pend_bin == qry_bin)) qry_word = pend_word;
        else                                 qry_word = bins_q[qry_bin];
    end

    // Stage A -> B: capture the merged word and its bin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_v    <= 1'b0;
            pend_bin  <= '0;
            pend_word <= '0;
        end else begin
            pend_v    <= ins_en;
            pend_bin  <= ins_bin;
            pend_word <= rd_fwd | ins_mask;
        end
    end

    // Stage B: write the merged word back; reset empties every bin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < int'(NBINS); b++) bins_q[b] <= '0;
        end else if (pend_v) begin
            bins_q[pend_bin] <= pend_word;
        end
    end

    // R3
    mask_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ins_en |=> pend_v && ((pend_word & $past(ins_mask)) == $past(ins_mask)));

    // R10
    fwd_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_en && pend_v && (pend_bin == ins_bin))
        |=> ((pend_word & $past(pend_word)) == $past(pend_word)));

endmodule

// File: rtl/mpbc_decode.sv
// Query decoder: ANDs the level words, checks for exactly one survivor,
// removes the rotation and registers the response.
// Assumes NUM_OUT is a power of two. Latency is one cycle.
module mpbc_decode
    import mpbc_pkg::*;
#(
    parameter int unsigned NUM_OUT = 8,
    parameter int unsigned LEVELS  = 3,
    localparam int unsigned OW     = idx_width(NUM_OUT)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      qry_valid,
    input  logic [LEVELS*NUM_OUT-1:0] words,
    input  logic [OW-1:0]             qry_rot,
    output logic                      rsp_valid,
    output logic                      rsp_hit,
    output logic [OW-1:0]             rsp_outcome
);
    logic [NUM_OUT-1:0] andw;
    logic [OW-1:0]      bit_idx;
    logic [OW-1:0]      out_c;
    logic               single;

    // AND the addressed words of all levels.
    always_comb begin
        andw = '1;
        for (int k = 0; k < int'(LEVELS); k++) andw &= words[k*NUM_OUT +: NUM_OUT];
    end

    // Locate the surviving bit and undo the rotation.
    always_comb begin
        bit_idx = '0;
        for (int b = 0; b < int'(NUM_OUT); b++) if (andw[b]) bit_idx = OW'(b);
        single = ($countones(andw) == 1);
        out_c  = OW'(wrap_pow2(32'(bit_idx) + NUM_OUT - 32'(qry_rot), NUM_OUT));
    end

    // Register the response; a miss reports outcome 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_hit     <= 1'b0;
            rsp_outcome <= '0;
        end else begin
            rsp_valid   <= qry_valid;
            rsp_hit     <= qry_valid && single;
            rsp_outcome <= (qry_valid && single) ? out_c : '0;
        end
    end

    // R2
    hit_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_valid);

    // R4 R5
    not_single_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (qry_valid && ($countones(andw) != 1)) |=> !rsp_hit);

    // R4
    miss_zero_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_hit |-> (rsp_outcome == '0));

endmodule

// File: rtl/mp_bloom_cache.sv
// Top: multi-outcome Bloom classification cache.
// Builds the rotated one-hot insert mask, instantiates LEVELS storage
// levels and feeds their query words to the decoder.
// Assumes NUM_OUT is a power of two and hashes arrive already computed.
module mp_bloom_cache
    import mpbc_pkg::*;
#(
    parameter int unsigned NUM_OUT = 8,
    parameter int unsigned LEVELS  = 3,
    parameter int unsigned BIN_AW  = 4,
    localparam int unsigned OW     = idx_width(NUM_OUT),
    localparam int unsigned HW     = LEVELS * BIN_AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ins_valid,
    input  logic [HW-1:0] ins_hash,
    input  logic [OW-1:0] ins_rot,
    input  logic [OW-1:0] ins_outcome,
    input  logic          qry_valid,
    input  logic [HW-1:0] qry_hash,
    input  logic [OW-1:0] qry_rot,
    output logic          rsp_valid,
    output logic          rsp_hit,
    output logic [OW-1:0] rsp_outcome
);
    logic [OW-1:0]             ins_bit;
    logic [NUM_OUT-1:0]        ins_mask;
    logic [LEVELS*NUM_OUT-1:0] lvl_words;

    // Rotated bit position and its one-hot mask.
    always_comb begin
        ins_bit  = OW'(wrap_pow2(32'(ins_outcome) + 32'(ins_rot), NUM_OUT));
        ins_mask = NUM_OUT'(1) << ins_bit;
    end

    for (genvar k = 0; k < int'(LEVELS); k++) begin : g_lvl
        mpbc_level #(.NUM_OUT(NUM_OUT), .BIN_AW(BIN_AW)) u_lvl (
            .clk      (clk),
            .rst_n    (rst_n),
            .ins_en   (ins_valid),
            .ins_bin  (ins_hash[k*BIN_AW +: BIN_AW]),
            .ins_mask (ins_mask),
            .qry_bin  (qry_hash[k*BIN_AW +: BIN_AW]),
            .qry_word (lvl_words[k*NUM_OUT +: NUM_OUT])
        );
    end

    mpbc_decode #(.NUM_OUT(NUM_OUT), .LEVELS(LEVELS)) u_dec (
        .clk         (clk),
        .rst_n       (rst_n),
        .qry_valid   (qry_valid),
        .words       (lvl_words),
        .qry_rot     (qry_rot),
        .rsp_valid   (rsp_valid),
        .rsp_hit     (rsp_hit),
        .rsp_outcome (rsp_outcome)
    );

    // R3
    ins_mask_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid |-> $onehot(ins_mask));

    // R2
    rsp_follows_qry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(qry_valid));

endmodule

// File: tb/mp_bloom_cache_tb.sv
`timescale 1ns/1ps
// Bench: table walk followed by directed reset and timing corner cases.
module mp_bloom_cache_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ins_valid = 1'b0;
    logic [11:0] ins_hash = '0;
    logic [2:0]  ins_rot = '0;
    logic [2:0]  ins_outcome = '0;
    logic        qry_valid = 1'b0;
    logic [11:0] qry_hash = '0;
    logic [2:0]  qry_rot = '0;
    logic        rsp_valid;
    logic        rsp_hit;
    logic [2:0]  rsp_outcome;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mp_bloom_cache #(.NUM_OUT(8), .LEVELS(3), .BIN_AW(4)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .ins_valid(ins_valid), .ins_hash(ins_hash), .ins_rot(ins_rot), .ins_outcome(ins_outcome),
        .qry_valid(qry_valid), .qry_hash(qry_hash), .qry_rot(qry_rot),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_outcome(rsp_outcome)
    );

    // Row: {op, hash[11:0], rot, outcome, exp_hit, exp_out}, one nibble per
    // field; op 1 = insert, 2 = query.
    localparam logic [31:0] VEC [14] = '{
        32'h2_123_0_0_0_0, // R1 R4: empty table misses
        32'h1_123_3_2_0_0, // R6: outcome 2, rot 3 stores bit 5
        32'h2_123_3_0_1_2, // R3: hit, outcome 2
        32'h2_123_0_0_1_5, // R6: rot 0 reports bit 5
        32'h1_456_5_6_0_0, // R7: outcome 6, rot 5 stores bit 3
        32'h2_456_5_0_1_6, // R7: wraps back to 6
        32'h2_456_0_0_1_3, // R7: rot 0 reports bit 3
        32'h2_153_3_0_0_0, // R11: bit missing in one level
        32'h1_789_1_1_0_0, // R8: insert elsewhere
        32'h2_123_3_0_1_2, // R8: earlier entry kept
        32'h1_123_0_0_0_0, // R5: second bit in same bins
        32'h2_123_3_0_0_0, // R5: two survivors -> miss
        32'h2_789_1_0_1_1, // R3: hit outcome 1
        32'h2_ABC_2_0_0_0  // R4: untouched bins miss
    };

    task automatic check(input string tag, input logic got_v, input logic got_h,
                         input logic [2:0] got_o, input logic exp_v, input logic exp_h,
                         input logic [2:0] exp_o);
        n_chk++;
        if (got_v !== exp_v || got_h !== exp_h || got_o !== exp_o) begin
            n_bad++;
            $display("FAIL %s: got v=%0b hit=%0b out=%0d, expected v=%0b hit=%0b out=%0d",
                     tag, got_v, got_h, got_o, exp_v, exp_h, exp_o);
        end
    endtask

    task automatic idle_inputs();
        ins_valid = 1'b0;
        qry_valid = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle_inputs();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Query alone and check the response one edge later.
    task automatic query(input string tag, input logic [11:0] h, input logic [2:0] r,
                         input logic eh, input logic [2:0] eo);
        qry_valid = 1'b1; qry_hash = h; qry_rot = r;
        @(negedge clk);
        qry_valid = 1'b0;
        check(tag, rsp_valid, rsp_hit, rsp_outcome, 1'b1, eh, eo);
    endtask

    initial begin
        do_reset();
        @(negedge clk);
        check("R1 reset state", rsp_valid, rsp_hit, rsp_outcome, 1'b0, 1'b0, 3'd0);

        // Table walk: one row per cycle.
        for (int k = 0; k < 14; k++) begin
            logic [31:0] v;
            v = VEC[k];
            if (v[31:28] == 4'h1) begin
                ins_valid = 1'b1; ins_hash = v[27:16]; ins_rot = v[14:12]; ins_outcome = v[10:8];
            end else begin
                qry_valid = 1'b1; qry_hash = v[27:16]; qry_rot = v[14:12];
            end
            @(negedge clk);
            if (v[31:28] == 4'h2)
                check($sformatf("table row %0d", k), rsp_valid, rsp_hit, rsp_outcome,
                      1'b1, v[4], v[2:0]);
            idle_inputs();
        end

        // R2: no response in a cycle that follows no query.
        @(negedge clk);
        check("R2 idle cycle", rsp_valid, rsp_hit, rsp_outcome, 1'b0, 1'b0, 3'd0);

        // R9: insert and query together sees the old table; one cycle later hits.
        ins_valid = 1'b1; ins_hash = 12'h2E7; ins_rot = 3'd0; ins_outcome = 3'd3;
        qry_valid = 1'b1; qry_hash = 12'h2E7; qry_rot = 3'd0;
        @(negedge clk);
        check("R9 same-cycle query", rsp_valid, rsp_hit, rsp_outcome, 1'b1, 1'b0, 3'd0);
        ins_valid = 1'b0;
        @(negedge clk);
        qry_valid = 1'b0;
        check("R9 next-cycle query", rsp_valid, rsp_hit, rsp_outcome, 1'b1, 1'b1, 3'd3);

        // R10: back-to-back inserts into the same bins keep both bits.
        ins_valid = 1'b1; ins_hash = 12'hDEF; ins_rot = 3'd0; ins_outcome = 3'd1;
        @(negedge clk);
        ins_outcome = 3'd4;
        @(negedge clk);
        ins_valid = 1'b0;
        query("R10 both bits kept", 12'hDEF, 3'd0, 1'b0, 3'd0);
        repeat (2) @(negedge clk);
        query("R10 after write-back", 12'hDEF, 3'd0, 1'b0, 3'd0);

        // R1: reset in mid-operation empties the bins.
        do_reset();
        @(negedge clk);
        query("R1 cleared entry 456", 12'h456, 3'd5, 1'b0, 3'd0);
        query("R1 cleared entry 789", 12'h789, 3'd1, 1'b0, 3'd0);

        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got running, expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule